// File: doc/BRIEF.md
# Secondary PLL Lock Timer and Peripheral Clock Source Selector

This block decides which of two clock generators feeds a peripheral clock and times how long the secondary generator needs before it is trusted. Software works through a small synchronous register bus with two 16-bit registers. The source register holds a select bit and two read-only status bits. The mode register holds the multiply and divide settings, an enable bit, a run bit, a read-only countdown and a read-only lock flag.

When the run bit is written from 0 to 1, an 8-bit countdown starts from a parameterised value. The countdown drops by one on every sixteenth reference clock. When it reaches zero, the lock flag rises. The peripheral is moved to the secondary generator only when software has selected it and the lock flag is set. The block also decodes the multiply factor K and the divide factor D. D depends on the divide bit and on whether K is odd or even. The frequency synthesis itself and the glitch-free clock switch are not part of this block.

Top module: `clksrc_lock_ctrl`

## Requirements
- R1: After reset, the source register (address 0) reads 0x0004 and the mode register (address 1) reads 0x0000.
- R2: In the source register, bit 0 is a read/write select bit (0 = primary generator, 1 = secondary generator). Bits 15:3 always read zero. Written values in bits 15:1 have no effect.
- R3: The mode register reads as multiply field in bits 15:12, divide bit 11, countdown in bits 10:3, enable bit 2, run bit 1 and lock flag bit 0. Writes update only bits 15:11, 2 and 1.
- R4: Output `mul_k` equals the multiply field plus one (range 1 to 16).
- R5: Output `div_d` is 1 when the divide bit is 0. When the divide bit is 1, `div_d` is 2 if K is odd and 4 if K is even.
- R6: A write that takes the run bit from 0 to 1 loads the countdown with LOCK_INIT (default 0xFF), clears the lock flag and restarts the divide-by-16 prescaler.
- R7: While the run bit is 1 and the countdown is non-zero, the countdown drops by one on the 16th clock edge after the load and on every 16th edge after that.
- R8: The countdown stops at zero and does not wrap. The lock flag becomes 1 on the edge after the countdown is zero with the run bit set, and it stays 1 until the run bit is cleared or reset is applied.
- R9: Writing the run bit to 0 clears the lock flag at once, freezes the countdown at its current value and stops the prescaler. Writing the run bit as 1 while it is already 1 does not reload the countdown.
- R10: Source-register bits 2:1 are always one-hot. Bit 1 and output `src_alt` are 1 exactly when the select bit and the lock flag are both 1. Otherwise bit 2 is 1.
- R11: Addresses other than 0 and 1 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference input clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write enable, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| src_alt | output | 1 | Effective source: 1 = secondary generator drives the peripheral |
| mul_k | output | 5 | Decoded multiply factor K |
| div_d | output | 3 | Decoded divide factor D |
| locked | output | 1 | Lock flag of the secondary generator |

## Verification
The hardest state to reach is a completed lock. It needs 16 × 255 reference cycles of undisturbed countdown, and any write that restarts or stops the run bit on the way throws that state away. The bench gets there with a long directed run that is followed by re-arm, redundant-arm and stop writes. These writes are placed a known number of edges from a prescaler tick, so the one-cycle relationship between a tick and a write is checked. Random register traffic with a fixed seed is then compared cycle by cycle against a bench model built from the requirements.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

    localparam int unsigned WORD_W  = 16;
    localparam int unsigned CNT_W   = 8;
    localparam int unsigned MULT_W  = 4;
    localparam int unsigned K_W     = MULT_W + 1;
    localparam int unsigned D_W     = 3;
    localparam int unsigned PRE_W   = 4;

    localparam int unsigned SRC_ADDR  = 0;
    localparam int unsigned MODE_ADDR = 1;

    typedef logic [WORD_W-1:0] word_t;

    // Mode register image, most significant field first
    typedef struct packed {
        logic [MULT_W-1:0] mult;
        logic              div;
        logic [CNT_W-1:0]  count;
        logic              enable;
        logic              run;
        logic              lock;
    } mode_reg_t;

    // Source register image
    typedef struct packed {
        logic [WORD_W-4:0] zero;
        logic              prim_src;
        logic              alt_src;
        logic              sel;
    } src_reg_t;

    function automatic logic [K_W-1:0] decode_k(input logic [MULT_W-1:0] m);
        return {1'b0, m} + K_W'(1);
    endfunction

    // K = m + 1 is even exactly when m is odd
    function automatic logic [D_W-1:0] decode_d(input logic [MULT_W-1:0] m,
                                                input logic              dv);
        if (!dv)      return D_W'(1);
        else if (m[0]) return D_W'(4);
        else           return D_W'(2);
    endfunction

endpackage

// File: rtl/clksrc_presc.sv
module clksrc_presc #(
    parameter int unsigned PW = clksrc_pkg::PRE_W
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic tick
);
    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst)              phase_q <= '0;
        else if (clr || !run) phase_q <= '0;
        else                  phase_q <= phase_q + PW'(1);
    end

    assign tick = run && !clr && (phase_q == {PW{1'b1}});

    // R7: the phase counter never advances while the countdown is halted
    p_phase_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !run |=> (phase_q == '0));
endmodule

// File: rtl/clksrc_lock_cnt.sv
module clksrc_lock_cnt #(
    parameter int unsigned CW = clksrc_pkg::CNT_W,
    parameter logic [CW-1:0] INIT = {CW{1'b1}}
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          run_q,
    input  logic          run_d,
    input  logic          tick,
    output logic [CW-1:0] cnt_q,
    output logic          lock_q
);
    logic          at_zero;
    logic [CW-1:0] cnt_d;
    logic          lock_d;

    assign at_zero = (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = INIT;
        else if (run_q && run_d && tick && !at_zero)
            cnt_d = cnt_q - CW'(1);
    end

    always_comb begin
        if (start || !run_d) lock_d = 1'b0;
        else                 lock_d = lock_q || (run_q && at_zero);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            lock_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            lock_q <= lock_d;
        end
    end

    p_arm_load_r6: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt_q == INIT) && !lock_q);
    p_floor_r8: assert property (@(posedge clk) disable iff (rst)
        (at_zero && !start) |=> (cnt_q == '0));
    p_lock_at_zero_r8: assert property (@(posedge clk) disable iff (rst)
        lock_q |-> (at_zero && run_q));
    p_hold_stopped_r9: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !start) |=> $stable(cnt_q));
    p_no_step_between_r7: assert property (@(posedge clk) disable iff (rst)
        (!tick && !start) |=> $stable(cnt_q));
endmodule

// File: rtl/clksrc_factor_dec.sv
module clksrc_factor_dec
    import clksrc_pkg::*;
(
    input  logic [MULT_W-1:0] mult,
    input  logic              div,
    output logic [K_W-1:0]    k,
    output logic [D_W-1:0]    d
);
    assign k = decode_k(mult);
    assign d = decode_d(mult, div);

    always_comb begin
        a_d_legal_r5: assert (d == D_W'(1) || d == D_W'(2) || d == D_W'(4));
        a_k_nonzero_r4: assert (k != '0);
    end
endmodule

// File: rtl/clksrc_lock_ctrl.sv
module clksrc_lock_ctrl
    import clksrc_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter logic [CNT_W-1:0] LOCK_INIT = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              src_alt,
    output logic [K_W-1:0]    mul_k,
    output logic [D_W-1:0]    div_d,
    output logic              locked
);
    localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(SRC_ADDR);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(MODE_ADDR);

    logic              sel_q;
    logic [MULT_W-1:0] mult_q;
    logic              div_q;
    logic              en_q;
    logic              run_q;
    logic              run_d;
    logic              wr_src;
    logic              wr_mode;
    logic              start;
    logic              tick;
    logic [CNT_W-1:0]  cnt;
    logic              lock;
    mode_reg_t         wimg;
    mode_reg_t         mode_img;
    src_reg_t          src_img;

    assign wr_src  = bus_we && (bus_addr == A_SRC);
    assign wr_mode = bus_we && (bus_addr == A_MODE);
    assign wimg    = mode_reg_t'(bus_wdata);
    assign run_d   = wr_mode ? wimg.run : run_q;
    assign start   = wr_mode && wimg.run && !run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= 1'b0;
            mult_q <= '0;
            div_q  <= 1'b0;
            en_q   <= 1'b0;
            run_q  <= 1'b0;
        end else begin
            if (wr_src) sel_q <= bus_wdata[0];
            if (wr_mode) begin
                mult_q <= wimg.mult;
                div_q  <= wimg.div;
                en_q   <= wimg.enable;
            end
            run_q <= run_d;
        end
    end

    clksrc_presc #(.PW(PRE_W)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .clr  (start || !run_d),
        .run  (run_q),
        .tick (tick)
    );

    clksrc_lock_cnt #(.CW(CNT_W), .INIT(LOCK_INIT)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .run_q  (run_q),
        .run_d  (run_d),
        .tick   (tick),
        .cnt_q  (cnt),
        .lock_q (lock)
    );

    clksrc_factor_dec u_dec (
        .mult (mult_q),
        .div  (div_q),
        .k    (mul_k),
        .d    (div_d)
    );

    always_comb begin
        src_img.zero     = '0;
        src_img.sel      = sel_q;
        src_img.alt_src  = sel_q && lock;
        src_img.prim_src = !(sel_q && lock);
        mode_img.mult    = mult_q;
        mode_img.div     = div_q;
        mode_img.count   = cnt;
        mode_img.enable  = en_q;
        mode_img.run     = run_q;
        mode_img.lock    = lock;
    end

    always_comb begin
        if (bus_addr == A_SRC)       bus_rdata = word_t'(src_img);
        else if (bus_addr == A_MODE) bus_rdata = word_t'(mode_img);
        else                         bus_rdata = '0;
    end

    assign src_alt = src_img.alt_src;
    assign locked  = lock;

    p_status_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $countones({src_img.prim_src, src_img.alt_src}) == 1);
    p_alt_needs_lock_r10: assert property (@(posedge clk) disable iff (rst)
        src_alt |-> (locked && sel_q));
    p_stop_clears_lock_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_mode && !wimg.run) |=> !locked);
    p_rearm_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_mode && wimg.run && run_q && !tick) |=> $stable(cnt));
endmodule

// File: tb/clksrc_lock_ctrl_test.sv
module clksrc_lock_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        src_alt;
    logic [4:0]  mul_k;
    logic [2:0]  div_d;
    logic        locked;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    // bench model of the register state
    logic       m_sel, m_div, m_en, m_run, m_lock;
    logic [3:0] m_mult, m_ph;
    logic [7:0] m_cnt;

    always #5 clk = ~clk;

    clksrc_lock_ctrl uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_alt(src_alt),
        .mul_k(mul_k), .div_d(div_d), .locked(locked)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [4:0] exp_k(input logic [3:0] m);
        return 5'(int'(m) + 1);
    endfunction

    function automatic logic [2:0] exp_d(input logic [3:0] m, input logic dv);
        int k = int'(m) + 1;
        if (!dv) return 3'd1;
        return (k % 2 == 1) ? 3'd2 : 3'd4;
    endfunction

    function automatic logic [15:0] exp_read(input logic [1:0] a);
        logic alt = m_sel & m_lock;
        case (a)
            2'd0:    return {13'd0, ~alt, alt, m_sel};
            2'd1:    return {m_mult, m_div, m_cnt, m_en, m_run, m_lock};
            default: return 16'h0;
        endcase
    endfunction

    task automatic model_reset();
        m_sel = 0; m_div = 0; m_en = 0; m_run = 0; m_lock = 0;
        m_mult = 0; m_ph = 0; m_cnt = 0;
    endtask

    task automatic compare_all();
        string rt;
        rt = (bus_addr == 2'd0) ? "R2" : (bus_addr == 2'd1) ? "R3" : "R11";
        check(rt, bus_rdata, exp_read(bus_addr));
        check("R4", 16'(mul_k), 16'(exp_k(m_mult)));
        check("R5", 16'(div_d), 16'(exp_d(m_mult, m_div)));
        check("R10", 16'(src_alt), 16'(m_sel & m_lock));
        check("R8", 16'(locked), 16'(m_lock));
    endtask

    // one clock with the given bus inputs; model advanced per requirements
    task automatic cyc(input logic [1:0] a, input logic w, input logic [15:0] d);
        logic wm, nrun, arm, stop, tk;
        logic       n_sel, n_div, n_en, n_lock;
        logic [3:0] n_mult, n_ph;
        logic [7:0] n_cnt;
        bus_addr = a; bus_we = w; bus_wdata = d;
        wm   = w && (a == 2'd1);
        nrun = wm ? d[1] : m_run;
        arm  = wm && d[1] && !m_run;
        stop = !nrun;
        n_sel = (w && a == 2'd0) ? d[0] : m_sel;
        n_mult = wm ? d[15:12] : m_mult;
        n_div  = wm ? d[11] : m_div;
        n_en   = wm ? d[2] : m_en;
        tk = m_run && !arm && !stop && (m_ph == 4'd15);
        n_ph = (arm || stop || !m_run) ? 4'd0 : m_ph + 4'd1;
        if (arm) n_cnt = 8'hFF;
        else if (m_run && nrun && tk && m_cnt != 0) n_cnt = m_cnt - 8'd1;
        else n_cnt = m_cnt;
        if (arm || stop) n_lock = 0;
        else n_lock = m_lock | (m_run && m_cnt == 0);
        @(posedge clk);
        m_sel = n_sel; m_mult = n_mult; m_div = n_div; m_en = n_en;
        m_run = nrun; m_ph = n_ph; m_cnt = n_cnt; m_lock = n_lock;
        @(negedge clk);
        compare_all();
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n, input logic [1:0] a);
        for (int i = 0; i < n; i++) cyc(a, 1'b0, 16'h0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] snap;
        void'($urandom(32'h0C1C_5A17));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        bus_addr = 2'd0;
        #1 check("R1", bus_rdata, 16'h0004);
        bus_addr = 2'd1;
        #1 check("R1", bus_rdata, 16'h0000);

        // R2: only the select bit is writable
        cyc(2'd0, 1'b1, 16'hFFFF);
        check("R2", bus_rdata, 16'h0005);

        // R6: arm with every bit set; read-only fields ignore written ones
        cyc(2'd1, 1'b1, 16'hFFFF);
        check("R6", bus_rdata, 16'hFFFE);
        check("R4", 16'(mul_k), 16'd16);
        check("R5", 16'(div_d), 16'd4);

        // R7: first step on the 16th edge after the load
        idle(15, 2'd1);
        check("R7", 16'(bus_rdata[10:3]), 16'h00FF);
        idle(1, 2'd1);
        check("R7", 16'(bus_rdata[10:3]), 16'h00FE);

        // R8: full countdown reaches zero, lock one edge later
        idle(4064, 2'd1);
        check("R8", 16'(bus_rdata[10:3]), 16'h0000);
        check("R8", 16'(locked), 16'd0);
        idle(1, 2'd0);
        check("R10", bus_rdata, 16'h0003);
        check("R10", 16'(src_alt), 16'd1);
        idle(40, 2'd1);
        check("R8", bus_rdata[10:0], 11'h001 | 11'h006);

        // R9: stop clears lock, count stays at zero
        cyc(2'd1, 1'b1, 16'hF804);
        check("R9", 16'(locked), 16'd0);
        check("R9", 16'(bus_rdata[10:3]), 16'h0000);

        // R6 re-arm, then redundant arm, then stop mid-count
        cyc(2'd1, 1'b1, 16'hF806);
        check("R6", 16'(bus_rdata[10:3]), 16'h00FF);
        idle(40, 2'd1);
        cyc(2'd1, 1'b1, 16'hF806);
        check("R9", 16'(bus_rdata[10:3]), 16'h00FD);
        idle(20, 2'd1);
        cyc(2'd1, 1'b1, 16'h2004);
        check("R9", 16'(bus_rdata[10:3]), 16'h00FC);
        check("R5", 16'(div_d), 16'd1);
        idle(40, 2'd1);
        check("R9", 16'(bus_rdata[10:3]), 16'h00FC);

        // R11: unmapped address
        snap = bus_rdata[10:3];
        cyc(2'd2, 1'b1, 16'hFFFF);
        check("R11", bus_rdata, 16'h0000);
        cyc(2'd3, 1'b1, 16'hFFFF);
        idle(1, 2'd1);
        check("R11", 16'(bus_rdata[10:3]), 16'(snap));

        // random traffic
        for (int i = 0; i < 8000; i++) begin
            logic [1:0]  ra = 2'($urandom_range(0, 3));
            logic        rw = ($urandom_range(0, 15) == 0);
            logic [15:0] rd = 16'($urandom);
            cyc(ra, rw, rd);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule